// File: doc/BRIEF.md
# Dual Master Trigger Output Selector

This block picks the synchronisation signals a master timer sends to slave timers and converters. It drives two trigger outputs, each steered by its own mode field. The first output has a 3-bit field and the second a 4-bit field. Either output can carry one of four sources: the software generate strobe, the effective counter enable, the update event, or the channel-1 capture/compare event. Either output can also carry one of the compare reference waveforms as a level.

The second output has more choices. It can pass the channel 5 and channel 6 references as levels. It can also produce one-cycle pulses from edges of the channel 4, 5 and 6 references, alone or two at a time. Each reference is compared with its own value from the previous clock cycle to detect edges. The outputs are combinational muxes over this registered edge history, so a pulse appears in the same cycle as the reference change that causes it.

Top module: `mtrig_sel`

## Requirements
- R1: Mode 0 on either output drives that output with `sw_gen`.
- R2: Mode 1 drives the output with the effective counter enable. This signal is `cnt_en_sw` when `gate_mode` is 0, and `cnt_en_sw AND trig_in` when `gate_mode` is 1.
- R3: Mode 2 drives the output with `upd_evt`.
- R4: Mode 3 drives the output high in every cycle in which `cc1_evt` is high, including back-to-back cycles.
- R5: Modes 4, 5, 6 and 7 drive the output with the level of `oc_ref` bit 0, 1, 2 and 3 (channels 1 to 4).
- R6: On `trg2` only, modes 8 and 9 drive the level of `oc_ref` bit 4 (channel 5) and bit 5 (channel 6).
- R7: On `trg2`, mode 10 gives a one-cycle pulse on every change of `oc_ref[3]`, and mode 11 does the same for `oc_ref[5]`. The pulse appears in the cycle where the new value is first present.
- R8: On `trg2`, mode 12 pulses on a rising edge of `oc_ref[3]` or of `oc_ref[5]`. Mode 13 pulses on a rising edge of `oc_ref[3]` or a falling edge of `oc_ref[5]`.
- R9: On `trg2`, mode 14 pulses on a rising edge of `oc_ref[4]` or of `oc_ref[5]`. Mode 15 pulses on a rising edge of `oc_ref[4]` or a falling edge of `oc_ref[5]`.
- R10: While `rst_n` is low, the edge-pulse modes output 0 and the edge history is held low. A reference already high in the first cycle after reset therefore counts as a rising edge.
- R11: The mode of one output has no effect on the other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode1 | input | 3 | Source select for `trg1` |
| mode2 | input | 4 | Source select for `trg2` |
| sw_gen | input | 1 | Software generate strobe |
| cnt_en_sw | input | 1 | Software counter-enable bit |
| gate_mode | input | 1 | High when the counter is gated by the trigger input |
| trig_in | input | 1 | Trigger input used for gating |
| upd_evt | input | 1 | Update event |
| cc1_evt | input | 1 | Channel-1 capture/compare event (flag-set strobe) |
| oc_ref | input | 6 | Compare references, bit 0 = channel 1 up to bit 5 = channel 6 |
| trg1 | output | 1 | First trigger output |
| trg2 | output | 1 | Second trigger output |

## Verification
The hardest case to reach is a combined edge mode in which the two references move in the same cycle or in opposite directions. In that case the right answer depends on the previous cycle of both references. The stimulus runs each of modes 10 to 15 over one shared reference sequence. That sequence contains simultaneous rises, simultaneous falls and crossed moves on channels 4, 5 and 6. The expected pulse is computed from the bench's own copy of the previous reference value. The reset case holds a reference high across reset release, which shows that the first cycle after reset is treated as a rising edge.

// File: rtl/mtrig_sel_pkg.sv
package mtrig_sel_pkg;

    localparam int unsigned NUM_REF  = 6;
    localparam int unsigned SEL_W    = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_GEN    = 4'd0,
        SRC_CEN    = 4'd1,
        SRC_UPD    = 4'd2,
        SRC_CC1    = 4'd3,
        SRC_LVL1   = 4'd4,
        SRC_LVL2   = 4'd5,
        SRC_LVL3   = 4'd6,
        SRC_LVL4   = 4'd7,
        SRC_LVL5   = 4'd8,
        SRC_LVL6   = 4'd9,
        SRC_ANY4   = 4'd10,
        SRC_ANY6   = 4'd11,
        SRC_R4R6   = 4'd12,
        SRC_R4F6   = 4'd13,
        SRC_R5R6   = 4'd14,
        SRC_R5F6   = 4'd15
    } src_sel_e;

    typedef struct packed {
        logic [NUM_REF-1:0] rise;
        logic [NUM_REF-1:0] fall;
    } edge_set_t;

endpackage

// File: rtl/mtrig_sel_edge.sv
module mtrig_sel_edge
    import mtrig_sel_pkg::*;
#(
    parameter int unsigned N = NUM_REF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] ref_i,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic [N-1:0] hist;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.hist = ref_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // one detector per reference; outputs are quiet while in reset
    for (genvar gi = 0; gi < N; gi++) begin : g_det
        assign rise_o[gi] = rst_n &  ref_i[gi] & ~st_q.hist[gi];
        assign fall_o[gi] = rst_n & ~ref_i[gi] &  st_q.hist[gi];
    end

endmodule

// File: rtl/mtrig_sel_mux.sv
module mtrig_sel_mux
    import mtrig_sel_pkg::*;
#(
    parameter int unsigned MW = SEL_W
) (
    input  logic [MW-1:0]      mode_i,
    input  logic               gen_i,
    input  logic               cen_i,
    input  logic               upd_i,
    input  logic               cc1_i,
    input  logic [NUM_REF-1:0] lvl_i,
    input  edge_set_t          edg_i,
    output logic               trg_o
);

    localparam bit HAS_EXT = (MW > 3);

    logic [SEL_W-1:0] sel;
    logic             ext_val;
    logic             base_val;

    always_comb begin
        sel = SEL_W'(mode_i);
    end

    // sources reachable by every selector width
    always_comb begin
        base_val = 1'b0;
        unique case (sel[2:0])
            3'd0: base_val = gen_i;
            3'd1: base_val = cen_i;
            3'd2: base_val = upd_i;
            3'd3: base_val = cc1_i;
            3'd4: base_val = lvl_i[0];
            3'd5: base_val = lvl_i[1];
            3'd6: base_val = lvl_i[2];
            default: base_val = lvl_i[3];
        endcase
    end

    if (HAS_EXT) begin : g_ext
        always_comb begin
            ext_val = 1'b0;
            unique case (src_sel_e'(sel))
                SRC_LVL5: ext_val = lvl_i[4];
                SRC_LVL6: ext_val = lvl_i[5];
                SRC_ANY4: ext_val = edg_i.rise[3] | edg_i.fall[3];
                SRC_ANY6: ext_val = edg_i.rise[5] | edg_i.fall[5];
                SRC_R4R6: ext_val = edg_i.rise[3] | edg_i.rise[5];
                SRC_R4F6: ext_val = edg_i.rise[3] | edg_i.fall[5];
                SRC_R5R6: ext_val = edg_i.rise[4] | edg_i.rise[5];
                SRC_R5F6: ext_val = edg_i.rise[4] | edg_i.fall[5];
                default:  ext_val = 1'b0;
            endcase
        end
        assign trg_o = sel[SEL_W-1] ? ext_val : base_val;
    end else begin : g_base
        assign ext_val = 1'b0;
        assign trg_o   = base_val;
    end

endmodule

// File: rtl/mtrig_sel.sv
module mtrig_sel
    import mtrig_sel_pkg::*;
#(
    parameter int unsigned M1W = 3,
    parameter int unsigned M2W = SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [M1W-1:0]     mode1,
    input  logic [M2W-1:0]     mode2,
    input  logic               sw_gen,
    input  logic               cnt_en_sw,
    input  logic               gate_mode,
    input  logic               trig_in,
    input  logic               upd_evt,
    input  logic               cc1_evt,
    input  logic [NUM_REF-1:0] oc_ref,
    output logic               trg1,
    output logic               trg2
);

    logic      cen_eff;
    edge_set_t edges;

    always_comb begin
        cen_eff = cnt_en_sw & (gate_mode ? trig_in : 1'b1);
    end

    mtrig_sel_edge #(.N(NUM_REF)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_i  (oc_ref),
        .rise_o (edges.rise),
        .fall_o (edges.fall)
    );

    mtrig_sel_mux #(.MW(M1W)) u_mux1 (
        .mode_i (mode1),
        .gen_i  (sw_gen),
        .cen_i  (cen_eff),
        .upd_i  (upd_evt),
        .cc1_i  (cc1_evt),
        .lvl_i  (oc_ref),
        .edg_i  (edges),
        .trg_o  (trg1)
    );

    mtrig_sel_mux #(.MW(M2W)) u_mux2 (
        .mode_i (mode2),
        .gen_i  (sw_gen),
        .cen_i  (cen_eff),
        .upd_i  (upd_evt),
        .cc1_i  (cc1_evt),
        .lvl_i  (oc_ref),
        .edg_i  (edges),
        .trg_o  (trg2)
    );

endmodule

// File: rtl/mtrig_sel_chk.sv
module mtrig_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode1,
    input logic [3:0] mode2,
    input logic       sw_gen,
    input logic       cnt_en_sw,
    input logic       gate_mode,
    input logic       trig_in,
    input logic       upd_evt,
    input logic       cc1_evt,
    input logic [5:0] oc_ref,
    input logic       trg1,
    input logic       trg2
);

    logic past_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 3'd0) |-> (trg1 == sw_gen));

    p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode2 == 4'd1 && gate_mode && !trig_in) |-> !trg2);

    p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode2 == 4'd2) |-> (trg2 == upd_evt));

    p_cc1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 == 3'd3) |-> (trg1 == cc1_evt));

    p_level6_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode2 == 4'd9) |-> (trg2 == oc_ref[5]));

    p_any4_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && mode2 == 4'd10 && trg2) |-> (oc_ref[3] != $past(oc_ref[3])));

    p_r4f6_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && mode2 == 4'd13 && trg2) |->
        ((oc_ref[3] && !$past(oc_ref[3])) || (!oc_ref[5] && $past(oc_ref[5]))));

    p_r5r6_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && mode2 == 4'd14 && trg2) |->
        ((oc_ref[4] && !$past(oc_ref[4])) || (oc_ref[5] && !$past(oc_ref[5]))));

    p_rst_quiet_r10: assert property (@(posedge clk)
        (!rst_n && mode2 >= 4'd10) |-> !trg2);

endmodule

bind mtrig_sel mtrig_sel_chk u_chk (.*);

// File: tb/mtrig_sel_bench.sv
`timescale 1ns/1ps
module mtrig_sel_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode1 = '0;
    logic [3:0] mode2 = '0;
    logic       sw_gen = 1'b0, cnt_en_sw = 1'b0, gate_mode = 1'b0, trig_in = 1'b0;
    logic       upd_evt = 1'b0, cc1_evt = 1'b0;
    logic [5:0] oc_ref = '0;
    logic       trg1, trg2;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    mtrig_sel u_mtrig_sel (
        .clk(clk), .rst_n(rst_n), .mode1(mode1), .mode2(mode2),
        .sw_gen(sw_gen), .cnt_en_sw(cnt_en_sw), .gate_mode(gate_mode),
        .trig_in(trig_in), .upd_evt(upd_evt), .cc1_evt(cc1_evt),
        .oc_ref(oc_ref), .trg1(trg1), .trg2(trg2)
    );

    // row: {mode1, mode2, {gen,cen,gate,trig,upd,cc1}, oc_ref, exp1, exp2}
    localparam int NV = 14;
    localparam logic [20:0] TBL [0:NV-1] = '{
        {3'd0, 4'd0, 6'b100000, 6'b000000, 1'b1, 1'b1},  // R1
        {3'd0, 4'd0, 6'b011111, 6'b111111, 1'b0, 1'b0},  // R1
        {3'd1, 4'd1, 6'b010000, 6'b000000, 1'b1, 1'b1},  // R2
        {3'd1, 4'd1, 6'b011000, 6'b000000, 1'b0, 1'b0},  // R2
        {3'd1, 4'd1, 6'b011100, 6'b000000, 1'b1, 1'b1},  // R2
        {3'd1, 4'd1, 6'b000100, 6'b000000, 1'b0, 1'b0},  // R2
        {3'd2, 4'd2, 6'b000010, 6'b000000, 1'b1, 1'b1},  // R3
        {3'd3, 4'd3, 6'b000001, 6'b000000, 1'b1, 1'b1},  // R4
        {3'd3, 4'd2, 6'b000001, 6'b000000, 1'b1, 1'b0},  // R4 / R11
        {3'd4, 4'd7, 6'b000000, 6'b001000, 1'b0, 1'b1},  // R5
        {3'd5, 4'd6, 6'b000000, 6'b000010, 1'b1, 1'b0},  // R5
        {3'd6, 4'd8, 6'b000000, 6'b010100, 1'b1, 1'b1},  // R5 / R6
        {3'd7, 4'd9, 6'b000000, 6'b100000, 1'b0, 1'b1},  // R6
        {3'd7, 4'd9, 6'b000000, 6'b001000, 1'b1, 1'b0}   // R5 / R6
    };

    localparam int NS = 10;
    localparam logic [5:0] SEQ [0:NS-1] = '{
        6'b000000, 6'b001000, 6'b101000, 6'b111000, 6'b011000,
        6'b000000, 6'b100000, 6'b110000, 6'b010000, 6'b101000
    };

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    function automatic logic model_edge(input logic [3:0] m, input logic [5:0] pv,
                                        input logic [5:0] cu);
        logic [5:0] r, f;
        r = cu & ~pv;
        f = ~cu & pv;
        case (m)
            4'd10:   return r[3] | f[3];
            4'd11:   return r[5] | f[5];
            4'd12:   return r[3] | r[5];
            4'd13:   return r[3] | f[5];
            4'd14:   return r[4] | r[5];
            default: return r[4] | f[5];
        endcase
    endfunction

    initial begin : watchdog
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [5:0] prev;
        repeat (3) @(negedge clk);
        // R10: reset state, level and pulse modes quiet
        mode1 = 3'd0; mode2 = 4'd12; oc_ref = 6'b101000;
        #1;
        check("R10 reset trg1", trg1, 1'b0);
        check("R10 reset trg2", trg2, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 first cycle rising", trg2, 1'b1);
        @(negedge clk); #1;
        check("R10 held high no pulse", trg2, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {mode1, mode2, sw_gen, cnt_en_sw, gate_mode, trig_in, upd_evt, cc1_evt,
             oc_ref} = TBL[i][20:2];
            #1;
            check($sformatf("R1-table row %0d trg1", i), trg1, TBL[i][1]);
            check($sformatf("R1-table row %0d trg2", i), trg2, TBL[i][0]);
        end
        {sw_gen, cnt_en_sw, gate_mode, trig_in, upd_evt, cc1_evt} = '0;

        // R4: back-to-back capture events each give a high output
        mode1 = 3'd3; mode2 = 4'd3;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cc1_evt = 1'b1;
            #1;
            check("R4 back-to-back trg2", trg2, 1'b1);
        end
        @(negedge clk); cc1_evt = 1'b0; #1;
        check("R4 idle", trg1, 1'b0);

        // R7 R8 R9: edge modes over a shared sequence; R11 trg1 unaffected
        mode1 = 3'd0;
        prev  = oc_ref;
        for (int m = 10; m < 16; m++) begin
            mode2 = 4'(m);
            for (int s = 0; s < NS; s++) begin
                @(negedge clk);
                oc_ref = SEQ[s];
                #1;
                check($sformatf("R7/R8/R9 mode %0d step %0d", m, s), trg2,
                      model_edge(4'(m), prev, SEQ[s]));
                check("R11 trg1 unaffected", trg1, 1'b0);
                prev = SEQ[s];
            end
        end

        // R7: pulse lasts a single cycle when reference stays
        mode2 = 4'd10;
        @(negedge clk); oc_ref = 6'b000000; prev = 6'b000000;
        @(negedge clk); oc_ref = 6'b001000; #1;
        check("R7 pulse", trg2, 1'b1);
        @(negedge clk); #1;
        check("R7 single cycle", trg2, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule